// File: doc/BRIEF.md
# Six-State Hardwired Instruction Sequencer

This block is the control unit of a minimal 8-bit accumulator machine. A one-hot timing ring steps through six states, T1 to T6. In each state the block decodes the 4-bit opcode held by the instruction register and drives a 12-bit control word to the datapath: program counter, memory address register, RAM, instruction register, accumulator, B register, ALU and output register.

States T1 to T3 fetch the instruction. T1 puts the program counter on the bus and loads the memory address register. T2 increments the program counter. T3 puts the RAM word on the bus and loads the instruction register. States T4 to T6 execute the opcode, after which the ring returns to T1. A halt opcode freezes the ring and raises a halted flag. Only clear releases it.

The control word has a fixed bit order, and some of its signals are active low. Every field position below is part of the contract with the datapath. Bit 11 is PC increment (high). Bit 10 is PC-to-bus (high). Bit 9 is address-register load (low). Bit 8 is RAM-to-bus (low). Bit 7 is instruction-register load (low). Bit 6 is operand-to-bus (low). Bit 5 is accumulator load (low). Bit 4 is accumulator-to-bus (high). Bit 3 is subtract select (high). Bit 2 is ALU-to-bus (high). Bit 1 is B load (low). Bit 0 is output-register load (low). The idle word, with every signal deasserted, is 0x3E3.

Top module: `ring_sequencer`

## Requirements
- R1: While `clr` is high, `ctrl` equals the idle word 0x3E3 and `halted` is 0. After `clr` falls, the ring is in T1.
- R2: The fetch words are fixed for every opcode: T1 = 0x5E3, T2 = 0xBE3 and T3 = 0x263.
- R3: Load opcode 0000: T4 = 0x1A3 (operand to bus, address load), T5 = 0x2C3 (RAM to bus, accumulator load), T6 = 0x3E3.
- R4: Add opcode 0001: T4 = 0x1A3, T5 = 0x2E1 (RAM to bus, B load), T6 = 0x3C7 (ALU to bus, accumulator load).
- R5: Subtract opcode 0010 follows the add schedule, except that T6 = 0x3CF (subtract select also high).
- R6: Output opcode 1110: T4 = 0x3F2 (accumulator to bus, output load), T5 = 0x3E3, T6 = 0x3E3.
- R7: Halt opcode 1111 in T4 gives the idle word in that cycle. From the next cycle on, `halted` is 1, `ctrl` stays idle and the ring holds, whatever the opcode, until `clr`.
- R8: Any other opcode gives the idle word in T4 to T6, and the ring keeps running.
- R9: Without halt or clear, the ring advances one state per clock and wraps from T6 back to T1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the ring advances on the rising edge |
| clr | input | 1 | Asynchronous active-high clear |
| opcode | input | 4 | High nibble of the instruction register |
| ctrl | output | 12 | Control word, bit 11 = PC increment down to bit 0 = output load |
| halted | output | 1 | High once a halt has executed, until clear |

## Verification
Two situations are hard to reach from the ports. The first is a halt that lands in T4 while other opcodes are offered in the fetch states. The second is clear arriving in the middle of an execute state or during a long halt. The random stimulus changes the opcode on every cycle, so the decode runs in all six states with arbitrary opcodes. When a halt occurs, the stimulus keeps the block halted for several cycles under random opcodes, then clears it. Clear is also injected at random ring positions. A reference model of the ring predicts the exact word for every cycle.

// File: rtl/ring_sequencer.sv
module ring_sequencer (
  input  logic        clk,
  input  logic        clr,
  input  logic [3:0]  opcode,
  output logic [11:0] ctrl,
  output logic        halted
);
  localparam int NSTATE = 6;

  localparam logic [3:0] OP_LOAD = 4'b0000;
  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_SUB  = 4'b0010;
  localparam logic [3:0] OP_OUT  = 4'b1110;
  localparam logic [3:0] OP_HALT = 4'b1111;

  localparam int B_INC  = 11;
  localparam int B_PCEN = 10;
  localparam int B_MAR  = 9;
  localparam int B_RAM  = 8;
  localparam int B_IRL  = 7;
  localparam int B_IRE  = 6;
  localparam int B_ACCL = 5;
  localparam int B_ACCE = 4;
  localparam int B_SUB  = 3;
  localparam int B_ALUE = 2;
  localparam int B_BL   = 1;
  localparam int B_OUTL = 0;

  localparam logic [11:0] IDLE = 12'h3E3;

  logic [NSTATE-1:0] ring;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      ring   <= NSTATE'(1);
      halted <= 1'b0;
    end else if (!halted) begin
      if (ring[3] && opcode == OP_HALT) halted <= 1'b1;
      else ring <= {ring[NSTATE-2:0], ring[NSTATE-1]};
    end
  end

  always_comb begin
    ctrl = IDLE;
    if (!clr && !halted) begin
      if (ring[0]) begin
        ctrl[B_PCEN] = 1'b1;
        ctrl[B_MAR]  = 1'b0;
      end else if (ring[1]) begin
        ctrl[B_INC]  = 1'b1;
      end else if (ring[2]) begin
        ctrl[B_RAM]  = 1'b0;
        ctrl[B_IRL]  = 1'b0;
      end else if (ring[3]) begin
        if (opcode == OP_LOAD || opcode == OP_ADD || opcode == OP_SUB) begin
          ctrl[B_IRE] = 1'b0;
          ctrl[B_MAR] = 1'b0;
        end else if (opcode == OP_OUT) begin
          ctrl[B_ACCE] = 1'b1;
          ctrl[B_OUTL] = 1'b0;
        end
      end else if (ring[4]) begin
        if (opcode == OP_LOAD) begin
          ctrl[B_RAM]  = 1'b0;
          ctrl[B_ACCL] = 1'b0;
        end else if (opcode == OP_ADD || opcode == OP_SUB) begin
          ctrl[B_RAM] = 1'b0;
          ctrl[B_BL]  = 1'b0;
        end
      end else if (ring[5]) begin
        if (opcode == OP_ADD || opcode == OP_SUB) begin
          ctrl[B_ALUE] = 1'b1;
          ctrl[B_ACCL] = 1'b0;
          ctrl[B_SUB]  = (opcode == OP_SUB);
        end
      end
    end
  end
endmodule

// File: rtl/ring_sequencer_chk.sv
module ring_sequencer_chk (
  input logic        clk,
  input logic        clr,
  input logic [3:0]  opcode,
  input logic [11:0] ctrl,
  input logic        halted,
  input logic [5:0]  ring
);
  // R9
  ring_onehot_chk: assert property (@(posedge clk) disable iff (clr) $onehot(ring));

  // R9
  ring_wrap_chk: assert property (@(posedge clk) disable iff (clr) (ring[5] && !halted) |=> ring[0]);

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (clr) ring[2] |=> ring[3]);

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (clr) halted |=> halted && $stable(ring));

  // R7
  halt_enter_chk: assert property (@(posedge clk) disable iff (clr) (ring[3] && opcode == 4'hF && !halted) |=> halted);

  // R7
  halt_idle_chk: assert property (@(posedge clk) disable iff (clr) halted |-> ctrl == 12'h3E3);

  // R6
  out_word_chk: assert property (@(posedge clk) disable iff (clr) (ring[3] && !halted && opcode == 4'hE) |-> ctrl == 12'h3F2);

  // R1
  clr_idle_chk: assert property (@(posedge clk) clr |-> (ctrl == 12'h3E3 && !halted));
endmodule

bind ring_sequencer ring_sequencer_chk u_chk (
  .clk(clk), .clr(clr), .opcode(opcode), .ctrl(ctrl), .halted(halted), .ring(ring)
);

// File: tb/ring_sequencer_bench.sv
`timescale 1ns/1ps
module ring_sequencer_bench;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic [11:0] ctrl;
  logic        halted;

  int checks = 0;
  int errors = 0;
  int st = 1;
  int prev_st = 0;
  bit hl = 1'b0;
  int hold = 0;

  always #4 clk = ~clk;

  ring_sequencer u_ring_sequencer (
    .clk(clk), .clr(clr), .opcode(opcode), .ctrl(ctrl), .halted(halted)
  );

  function automatic logic [11:0] exp_word(int s, logic [3:0] op, bit h, bit c);
    if (c || h) return 12'h3E3;
    case (s)
      1: return 12'h5E3;
      2: return 12'hBE3;
      3: return 12'h263;
      4: case (op)
           4'h0, 4'h1, 4'h2: return 12'h1A3;
           4'hE: return 12'h3F2;
           default: return 12'h3E3;
         endcase
      5: case (op)
           4'h0: return 12'h2C3;
           4'h1, 4'h2: return 12'h2E1;
           default: return 12'h3E3;
         endcase
      default: case (op)
           4'h1: return 12'h3C7;
           4'h2: return 12'h3CF;
           default: return 12'h3E3;
         endcase
    endcase
  endfunction

  function automatic string tag(int s, int ps, logic [3:0] op, bit h, bit c);
    if (c) return "R1";
    if (h) return "R7";
    if (s == 1 && ps == 6) return "R9";
    if (s <= 3) return "R2";
    case (op)
      4'h0: return "R3";
      4'h1: return "R4";
      4'h2: return "R5";
      4'hE: return "R6";
      4'hF: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic step(logic [3:0] op, bit c);
    logic [11:0] ew;
    clr = c;
    opcode = op;
    if (c) begin st = 1; hl = 1'b0; prev_st = 0; end
    #1;
    ew = exp_word(st, op, hl, c);
    checks++;
    if (ctrl !== ew || halted !== hl) begin
      errors++;
      $display("FAIL %s state T%0d op %h: ctrl=%h halted=%b expected ctrl=%h halted=%b",
               tag(st, prev_st, op, hl, c), st, op, ctrl, halted, ew, hl);
    end
    @(posedge clk);
    if (!c && !hl) begin
      prev_st = st;
      if (st == 4 && op == 4'hF) hl = 1'b1;
      else st = (st == 6) ? 1 : st + 1;
    end
    @(negedge clk);
  endtask

  task automatic run_instr(logic [3:0] op);
    for (int i = 0; i < 6; i++) step(op, 1'b0);
  endtask

  function automatic logic [3:0] pick_op();
    int r = int'($urandom_range(0, 99));
    if (r < 20) return 4'h0;
    if (r < 40) return 4'h1;
    if (r < 60) return 4'h2;
    if (r < 75) return 4'hE;
    if (r < 80) return 4'hF;
    return 4'($urandom_range(3, 13));
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: clear held
    step(4'h0, 1'b1);
    step(4'h5, 1'b1);
    // R2 R3 R4 R5 R6 R9: directed program
    run_instr(4'h0);
    run_instr(4'h1);
    run_instr(4'h1);
    run_instr(4'h2);
    run_instr(4'hE);
    // R8: unused opcodes
    run_instr(4'h7);
    run_instr(4'hC);
    // R7: halt then random opcodes, then clear
    for (int i = 0; i < 3; i++) step(4'h0, 1'b0);
    step(4'hF, 1'b0);
    for (int i = 0; i < 6; i++) step(4'($urandom_range(0, 15)), 1'b0);
    step(4'h1, 1'b1);
    // R1: clear in mid-execute
    for (int i = 0; i < 4; i++) step(4'h1, 1'b0);
    step(4'h1, 1'b1);
    run_instr(4'h2);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit c;
      if (hl) hold++; else hold = 0;
      c = (hold > 4) || ($urandom_range(0, 96) == 0);
      if (c) hold = 0;
      step(pick_op(), c);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule